// File: doc/BRIEF.md
# I2C Target Address Decoder with Event Queue

This block is the receive front end of an I2C target. It samples the bus lines through a two-stage synchroniser and finds START, repeated START and STOP conditions. It shifts in each address byte and compares it with two programmable own addresses. Each own address works in 7-bit or 10-bit form, and the block also answers the general call address. It acknowledges or refuses each byte by pulling SDA low, or not, during the ninth clock.

Every received write byte goes into a small receive queue together with a set of flags. The same queue holds the STOP or repeated START that ends a write transfer to this target. Software can therefore replay the bus activity in order by popping the queue. A dummy pop removes an event entry. Sticky status bits record a completed write, a read request at the first address and a cancelled read, and an interrupt line is raised while any of them is set. Supplying read data and holding SCL low are not part of this block. During a read the block keeps SDA released.

Top module: `i2c_target_decoder`

## Requirements
- R1: SCL and SDA pass through two synchronising flops. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. An SDA change while SCL is low is never taken as a condition. Data bits are sampled on SCL rising edges, MSB first.
- R2: Register select 0 is the decode control. Bit 2 enables address 1 and bit 3 puts it in 10-bit form. Bit 4 enables address 2 and bit 5 puts it in 10-bit form. An enabled address in 7-bit form matches a first byte whose bits [7:1] equal its low 7 bits. Address 1 wins over address 2. On a match the block drives SDA low from the SCL falling edge after the eighth bit until the next falling edge.
- R3: A 10-bit address matches in two steps. The first byte must be 11110, then address bits [9:8], then a write bit, and it is acknowledged if some enabled 10-bit address has those upper bits. The second byte must then equal address bits [7:0]. A prefix byte with the read bit is acknowledged only when the current transfer already matched that 10-bit address.
- R4: The first byte 0x00 is a general call. It is acknowledged when decode bit 0 is set and the loop_master input is high, or when decode bit 1 is set and loop_master is low.
- R5: A first byte that nothing matches is refused, and so is a match to a disabled address. SDA stays released, and the block ignores the bus until the next START or STOP, with no queue entries.
- R6: Each data byte of an acknowledged write transfer is queued as an entry of 8 data bits and 7 flags. Flag 0 is data for address 1 and flag 1 is data for address 2. Flag 2 is set when an ACK was driven. Flag 3 always reads 0. Flag 4 marks the first byte after the address. The ACK follows register select 1: bit 0 for address 1, bit 1 for address 2, bit 2 for the general call. A byte that is refused because of that register is still queued, with flag 2 clear.
- R7: A STOP ends a write transfer that was acknowledged, and a repeated START can do the same. Either one queues an entry with data 0x00 and only flag 6 (STOP) or flag 5 (repeated START) set.
- R8: When the queue is full, an incoming data byte is refused and not queued, and an event entry is dropped. The queue depth is FIFO_DEPTH, default 4.
- R9: Status bit 0 is set while the queue holds an entry. Bit 1 is set by a STOP that ends a write transfer. Bit 2 is set when a read at address 1 is acknowledged. Bit 5 is set when a START or STOP ends a read phase. Writing register select 4 clears every status bit whose data bit is 1. irq is high while any status bit is set.
- R10: Registers are written with reg_wr. Select 2 loads address 1 from reg_wdata[9:0] and select 3 loads address 2.
- R11: The queue head is shown on fifo_data and fifo_flags while fifo_valid is high. A one-cycle fifo_pop removes it, and a pop of an empty queue has no effect.
- R12: After reset the queue is empty, all status bits are 0, irq is low, SDA is released and all control registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low (ACK) when high |
| loop_master | input | 1 | Current transfer comes from the local master |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 10 | Register write data |
| fifo_pop | input | 1 | Remove the queue head |
| fifo_valid | output | 1 | Queue head is valid |
| fifo_data | output | 8 | Head data byte |
| fifo_flags | output | 7 | Head event flags |
| status | output | 6 | Status bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench replays transfers through a bus-level master, and a queue-based model predicts every ACK and queue entry. It toggles SDA while SCL is low in the middle of a transfer. A decoder that took such a toggle for a START or STOP would corrupt the data entries that follow. It runs a 10-bit transfer with a repeated START into a 7-bit transfer, a wrong 10-bit low byte, and a 7-bit byte that equals the low bits of an address set to 10-bit form. A wrong decoder would ACK a foreign address, or drop the repeated-START entry, or put the first-byte flag on the wrong byte. Further cases cover a full queue, which must refuse the fifth byte and drop the STOP entry, and a general call from the local master with only the external-master enable set. The last cases are a read ended by STOP, which must raise the read-request and cancel bits but queue nothing, and a pop of an empty queue.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR2,
        ST_DATA,
        ST_READ,
        ST_IGNORE
    } tgt_state_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_A1,
        SEL_A2,
        SEL_GC
    } match_e;

    localparam int FLAG_W   = 7;
    localparam int FL_DV1   = 0;
    localparam int FL_DV2   = 1;
    localparam int FL_ACK   = 2;
    localparam int FL_FIRST = 4;
    localparam int FL_RST   = 5;
    localparam int FL_STOP  = 6;

    typedef struct packed {
        logic [7:0]        data;
        logic [FLAG_W-1:0] flags;
    } fifo_entry_t;

    localparam logic [2:0] REG_DEC  = 3'd0;
    localparam logic [2:0] REG_RX   = 3'd1;
    localparam logic [2:0] REG_A1   = 3'd2;
    localparam logic [2:0] REG_A2   = 3'd3;
    localparam logic [2:0] REG_STAT = 3'd4;

    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    function automatic logic hit7(input logic en, input logic ten,
                                  input logic [9:0] a, input logic [7:0] b);
        return en && !ten && (b[7:1] == a[6:0]);
    endfunction

endpackage

// File: rtl/i2ct_bus_sync.sv
module i2ct_bus_sync (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_o,
    output logic stop_o
);
    logic scl_m, scl_s, scl_p;
    logic sda_m, sda_s, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            {scl_m, scl_s, scl_p} <= 3'b111;
            {sda_m, sda_s, sda_p} <= 3'b111;
        end else begin
            scl_m <= scl_i;  scl_s <= scl_m;  scl_p <= scl_s;
            sda_m <= sda_i;  sda_s <= sda_m;  sda_p <= sda_s;
        end
    end

    assign sda_o    = sda_s;
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_o  = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_o   = scl_s & scl_p & ~sda_p & sda_s;

    // R1
    start_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        (start_o || stop_o) |-> (scl_s && $past(scl_s)));

endmodule

// File: rtl/i2ct_fifo.sv
module i2ct_fifo
    import i2ct_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  fifo_entry_t din,
    input  logic        pop,
    output fifo_entry_t dout,
    output logic        valid,
    output logic        full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    fifo_entry_t     mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign valid   = (cnt != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !valid && !push) |=> !valid);

endmodule

// File: rtl/i2c_target_decoder.sv
module i2c_target_decoder
    import i2ct_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int REG_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             loop_master,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             fifo_pop,
    output logic             fifo_valid,
    output logic [7:0]       fifo_data,
    output logic [6:0]       fifo_flags,
    output logic [5:0]       status,
    output logic             irq
);
    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    i2ct_bus_sync u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    logic [5:0]  dec_ctl;
    logic [2:0]  rx_ctl;
    logic [9:0]  addr1, addr2;
    tgt_state_e  st;
    match_e      sel;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic        cand1, cand2, first_pend, nack_ign, oe_q;
    logic        st_wc, st_rr, st_rc;

    fifo_entry_t push_ent, head;
    logic        push_req, fifo_full;

    i2ct_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push_req), .din(push_ent),
        .pop(fifo_pop), .dout(head), .valid(fifo_valid), .full(fifo_full)
    );

    // byte decode
    logic       rw, is_pre, is_gc, gc_ok, h1, h2, c1, c2, lo1, lo2;
    logic       ten_rd_ok, data_ack_en, ack_now, byte_done;
    logic [1:0] hi;

    always_comb begin
        rw     = shreg[0];
        hi     = shreg[2:1];
        is_pre = (shreg[7:3] == TEN_PREFIX);
        is_gc  = (shreg == 8'h00);
        gc_ok  = loop_master ? dec_ctl[0] : dec_ctl[1];
        h1     = hit7(dec_ctl[2], dec_ctl[3], addr1, shreg);
        h2     = hit7(dec_ctl[4], dec_ctl[5], addr2, shreg);
        c1     = dec_ctl[2] && dec_ctl[3] && (addr1[9:8] == hi);
        c2     = dec_ctl[4] && dec_ctl[5] && (addr2[9:8] == hi);
        lo1    = cand1 && (shreg == addr1[7:0]);
        lo2    = cand2 && (shreg == addr2[7:0]);
        ten_rd_ok = (sel == SEL_A1 && c1) || (sel == SEL_A2 && c2);
        case (sel)
            SEL_A1:  data_ack_en = rx_ctl[0];
            SEL_A2:  data_ack_en = rx_ctl[1];
            SEL_GC:  data_ack_en = rx_ctl[2];
            default: data_ack_en = 1'b0;
        endcase
        byte_done = scl_fall && (bitcnt == 4'd8);
        case (st)
            ST_ADDR:  ack_now = is_pre ? (rw ? ten_rd_ok : (c1 || c2))
                              : is_gc ? (gc_ok && !rw) : (h1 || h2);
            ST_ADDR2: ack_now = lo1 || lo2;
            ST_DATA:  ack_now = data_ack_en && !fifo_full;
            default:  ack_now = 1'b0;
        endcase
    end

    // queue entry generation
    always_comb begin
        push_req = 1'b0;
        push_ent = '0;
        if (start_ev || stop_ev) begin
            if (st == ST_DATA && !fifo_full) begin
                push_req = 1'b1;
                push_ent.flags[stop_ev ? FL_STOP : FL_RST] = 1'b1;
            end
        end else if (byte_done && st == ST_DATA && !fifo_full) begin
            push_req = 1'b1;
            push_ent.data            = shreg;
            push_ent.flags[FL_DV1]   = (sel == SEL_A1);
            push_ent.flags[FL_DV2]   = (sel == SEL_A2);
            push_ent.flags[FL_ACK]   = data_ack_en;
            push_ent.flags[FL_FIRST] = first_pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_ctl <= '0;  rx_ctl <= '0;  addr1 <= '0;  addr2 <= '0;
            st <= ST_IDLE;  sel <= SEL_NONE;  bitcnt <= '0;  shreg <= '0;
            cand1 <= 1'b0;  cand2 <= 1'b0;  first_pend <= 1'b0;
            nack_ign <= 1'b0;  oe_q <= 1'b0;
            st_wc <= 1'b0;  st_rr <= 1'b0;  st_rc <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_sel)
                    REG_DEC:  dec_ctl <= reg_wdata[5:0];
                    REG_RX:   rx_ctl  <= reg_wdata[2:0];
                    REG_A1:   addr1   <= reg_wdata[9:0];
                    REG_A2:   addr2   <= reg_wdata[9:0];
                    REG_STAT: begin
                        if (reg_wdata[1]) st_wc <= 1'b0;
                        if (reg_wdata[2]) st_rr <= 1'b0;
                        if (reg_wdata[5]) st_rc <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (start_ev) begin
                if (st == ST_READ) st_rc <= 1'b1;
                if (st == ST_IDLE) sel <= SEL_NONE;
                st <= ST_ADDR;  bitcnt <= '0;  oe_q <= 1'b0;  nack_ign <= 1'b0;
            end else if (stop_ev) begin
                if (st == ST_DATA) st_wc <= 1'b1;
                if (st == ST_READ) st_rc <= 1'b1;
                st <= ST_IDLE;  sel <= SEL_NONE;  oe_q <= 1'b0;  nack_ign <= 1'b0;
            end else if (st != ST_IDLE && st != ST_IGNORE) begin
                if (scl_rise) begin
                    if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
                    bitcnt <= bitcnt + 1'b1;
                end
                if (byte_done) begin
                    oe_q <= ack_now;
                    if (st == ST_DATA) first_pend <= 1'b0;
                    if (st == ST_ADDR || st == ST_ADDR2) begin
                        if (!ack_now) begin
                            nack_ign <= 1'b1;
                            sel      <= SEL_NONE;
                        end else if (st == ST_ADDR2) begin
                            sel <= lo1 ? SEL_A1 : SEL_A2;
                            st  <= ST_DATA;  first_pend <= 1'b1;
                        end else if (is_pre && !rw) begin
                            cand1 <= c1;  cand2 <= c2;  st <= ST_ADDR2;
                        end else if (is_pre) begin
                            st <= ST_READ;
                            if (sel == SEL_A1) st_rr <= 1'b1;
                        end else if (is_gc) begin
                            sel <= SEL_GC;  st <= ST_DATA;  first_pend <= 1'b1;
                        end else begin
                            sel <= h1 ? SEL_A1 : SEL_A2;
                            if (rw) begin
                                st <= ST_READ;
                                if (h1) st_rr <= 1'b1;
                            end else begin
                                st <= ST_DATA;  first_pend <= 1'b1;
                            end
                        end
                    end
                end else if (scl_fall && bitcnt == 4'd9) begin
                    oe_q   <= 1'b0;
                    bitcnt <= '0;
                    if (nack_ign) begin
                        st <= ST_IGNORE;  nack_ign <= 1'b0;
                    end
                end
            end
        end
    end

    assign sda_oe     = oe_q;
    assign fifo_data  = head.data;
    assign fifo_flags = head.flags;
    assign status     = {st_rc, 2'b00, st_rr, st_wc, fifo_valid};
    assign irq        = |status;

    // R5
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGNORE || st == ST_IDLE) |-> !sda_oe);

    // R2
    ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_fall));

    // R7
    event_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_valid && (fifo_flags[FL_STOP] || fifo_flags[FL_RST])) |-> (fifo_data == 8'h00));

    // R9
    wc_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> $past(stop_ev));

endmodule

// File: tb/i2c_target_decoder_bench.sv
module i2c_target_decoder_bench;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_drv = 1'b1, sda_drv = 1'b1;
    logic       loop_master = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [9:0] reg_wdata = '0;
    logic       fifo_pop = 1'b0;
    logic       sda_oe, fifo_valid, irq;
    logic [7:0] fifo_data;
    logic [6:0] fifo_flags;
    logic [5:0] status;
    logic       sda_line;

    int n_chk = 0, n_err = 0;
    logic [14:0] exp_q[$];

    always #4 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    i2c_target_decoder u_i2c_target_decoder (
        .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
        .loop_master(loop_master), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .fifo_pop(fifo_pop), .fifo_valid(fifo_valid),
        .fifo_data(fifo_data), .fifo_flags(fifo_flags), .status(status), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] s, input logic [9:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b0; wq(); scl_drv = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b1; wq(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wq(); scl_drv = 1'b1; wq(2); scl_drv = 1'b0; wq();
        end
        sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq();
        ack = !sda_line;
        wq(); scl_drv = 1'b0; wq();
    endtask

    task automatic xb(input string req, input logic [7:0] b, input logic exp_ack);
        logic a;
        send_byte(b, a);
        check(req, a, exp_ack);
    endtask

    task automatic expect_entry(input logic [7:0] d, input logic [6:0] f);
        exp_q.push_back({d, f});
    endtask

    task automatic drain(input string req);
        while (exp_q.size() > 0) begin
            logic [14:0] e;
            e = exp_q.pop_front();
            check(req, fifo_valid, 1);
            check(req, {fifo_data, fifo_flags}, e);
            @(negedge clk); fifo_pop = 1'b1;
            @(negedge clk); fifo_pop = 1'b0;
        end
        check(req, fifo_valid, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 fifo_valid", fifo_valid, 0);
        check("R12 status", status, 0);
        check("R12 irq", irq, 0);
        check("R12 sda_oe", sda_oe, 0);

        // R10 configuration: a1 7-bit 0x2A, a2 10-bit 0x1B5, GC from external masters
        wreg(3'd0, 10'h036);
        wreg(3'd1, 10'h007);
        wreg(3'd2, 10'h02A);
        wreg(3'd3, 10'h1B5);

        // S1: R2 7-bit write, R1 SDA toggles with SCL low ignored
        bus_start();
        xb("R2 addr1 7-bit ack", 8'h54, 1);
        sda_drv = 1'b0; wq(); sda_drv = 1'b1; wq(); sda_drv = 1'b0; wq();
        xb("R1 byte after SDA toggles", 8'h11, 1);
        xb("R6 data ack", 8'h22, 1);
        bus_stop();
        expect_entry(8'h11, 7'h15);
        expect_entry(8'h22, 7'h05);
        expect_entry(8'h00, 7'h40);
        check("R9 status after write", status, 6'h03);
        check("R9 irq set", irq, 1);
        drain("R6 R7 R1 write entries");
        check("R9 wc sticky", status, 6'h02);
        wreg(3'd4, 10'h002);
        check("R9 w1c clear", status, 0);

        // S2: R5 unmatched address
        bus_start();
        xb("R5 foreign addr nack", 8'h60, 0);
        xb("R5 data ignored", 8'h33, 0);
        bus_stop();
        drain("R5 no entries");
        check("R5 status", status, 0);

        // S3: R3 10-bit write, repeated start, then 7-bit
        bus_start();
        xb("R3 prefix ack", 8'hF2, 1);
        xb("R3 low byte ack", 8'hB5, 1);
        xb("R3 data ack", 8'h77, 1);
        bus_start();
        xb("R7 addr after rstart", 8'h54, 1);
        xb("R7 data after rstart", 8'h99, 1);
        bus_stop();
        expect_entry(8'h77, 7'h16);
        expect_entry(8'h00, 7'h20);
        expect_entry(8'h99, 7'h15);
        expect_entry(8'h00, 7'h40);
        drain("R3 R7 entries");
        wreg(3'd4, 10'h03F);

        // S4: R3 wrong low byte, 7-bit byte equal to low bits of a 10-bit address
        bus_start();
        xb("R3 prefix ack", 8'hF2, 1);
        xb("R3 wrong low nack", 8'hB4, 0);
        xb("R5 ignored after nack", 8'h01, 0);
        bus_stop();
        bus_start();
        xb("R2 10-bit addr not matched as 7-bit", 8'h6A, 0);
        bus_stop();
        drain("R3 no entries");

        // S5: R4 general call
        bus_start();
        xb("R4 gc external ack", 8'h00, 1);
        xb("R4 gc data ack", 8'h06, 1);
        bus_stop();
        expect_entry(8'h06, 7'h14);
        expect_entry(8'h00, 7'h40);
        drain("R4 gc entries");
        loop_master = 1'b1;
        bus_start();
        xb("R4 gc local nack", 8'h00, 0);
        bus_stop();
        loop_master = 1'b0;
        drain("R4 no entries");
        wreg(3'd4, 10'h03F);

        // S6: R6 data refused by receive control, still queued
        wreg(3'd1, 10'h006);
        bus_start();
        xb("R6 addr ack", 8'h54, 1);
        xb("R6 data nack", 8'h42, 0);
        bus_stop();
        expect_entry(8'h42, 7'h11);
        expect_entry(8'h00, 7'h40);
        drain("R6 nack entry");
        wreg(3'd1, 10'h007);
        wreg(3'd4, 10'h03F);

        // S7: R8 full queue
        bus_start();
        xb("R8 addr ack", 8'h54, 1);
        xb("R8 b0", 8'hA0, 1);
        xb("R8 b1", 8'hA1, 1);
        xb("R8 b2", 8'hA2, 1);
        xb("R8 b3", 8'hA3, 1);
        xb("R8 full nack", 8'hA4, 0);
        bus_stop();
        expect_entry(8'hA0, 7'h15);
        expect_entry(8'hA1, 7'h05);
        expect_entry(8'hA2, 7'h05);
        expect_entry(8'hA3, 7'h05);
        drain("R8 full entries");
        wreg(3'd4, 10'h03F);

        // S8: R9 read request and cancel
        bus_start();
        xb("R9 read addr ack", 8'h55, 1);
        check("R9 read request", status, 6'h04);
        xb("R9 read byte master nack", 8'hFF, 0);
        bus_stop();
        check("R9 read cancel", status, 6'h24);
        check("R9 irq", irq, 1);
        drain("R9 no read entries");
        wreg(3'd4, 10'h03F);
        check("R9 cleared", status, 0);

        // S9: R5 disabled address
        wreg(3'd0, 10'h032);
        bus_start();
        xb("R5 disabled addr nack", 8'h54, 0);
        bus_stop();

        // S10: R10 new address, R11 pop when empty
        wreg(3'd0, 10'h036);
        wreg(3'd2, 10'h05B);
        @(negedge clk); fifo_pop = 1'b1;
        @(negedge clk); fifo_pop = 1'b0;
        check("R11 empty pop", fifo_valid, 0);
        bus_start();
        xb("R10 new addr1 ack", 8'hB6, 1);
        xb("R10 data", 8'h5A, 1);
        bus_stop();
        expect_entry(8'h5A, 7'h15);
        expect_entry(8'h00, 7'h40);
        drain("R10 R11 entries");

        finish_run();
    end
endmodule